// File: doc/BRIEF.md
# Syntax-Element RAM Read Arbiter

This block shares the single read port of the per-macroblock syntax-element memory between two consumers. The first is the coefficient reorder path, which must keep the inverse-transform input buffer supplied. The second is the parameter path, which recovers prediction modes, motion vectors and loop-filter strengths. Each consumer raises a request together with a word address. The arbiter decides each cycle which consumer drives the memory port. It then hands the read word back on that consumer's own response channel a fixed number of cycles later.

The coefficient path wins by default. Often a coefficient is already known to be zero, and in that case the arbiter accepts it without touching the memory. It later returns a zero word in its place, and the free port cycle goes to the parameter path. While the transform buffer signals that it is full, the coefficient path is stalled and its request stays pending, so the parameter path owns the port. Both channels keep responses in grant order, so zero words sit in scan order among real coefficient reads.

Top module: `synelem_rd_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, neither response valid is high.
- R2: With `xform_full` low, a coefficient request whose `coef_zero` is low is granted in the same cycle: `coef_gnt` high, `ram_re` high, `ram_addr` equal to `coef_addr`.
- R3: When R2 applies, a simultaneous parameter request is not granted in that cycle (`parm_gnt` low).
- R4: With `xform_full` low, a coefficient request with `coef_zero` high is accepted through `coef_zack` and causes no memory read for the coefficient. If a parameter request is present in that cycle, it gets the port (`parm_gnt` high, `ram_addr` equal to `parm_addr`).
- R5: While `xform_full` is high, neither `coef_gnt` nor `coef_zack` is asserted, and a parameter request is granted in that cycle.
- R6: `coef_gnt` and `parm_gnt` are never high together. Each is high only in cycles where its own request is high. `ram_re` is high exactly when one of them is high.
- R7: `RD_LAT` cycles after a grant, the granted client's response valid is high and its response data equals the memory word at the granted address. A grant to one client produces no response on the other client's channel.
- R8: `RD_LAT` cycles after a `coef_zack`, `rsp_coef_valid` is high with `rsp_coef_data` equal to zero. Coefficient responses appear in the order in which the coefficient requests were accepted.
- R9: With no request presented, or only a stalled coefficient request, `ram_re` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_req | input | 1 | Coefficient path requests a word |
| coef_zero | input | 1 | Requested coefficient is known to be zero |
| coef_addr | input | ADDR_W | Coefficient word address |
| parm_req | input | 1 | Parameter path requests a word |
| parm_addr | input | ADDR_W | Parameter word address |
| xform_full | input | 1 | Inverse-transform input buffer is full |
| coef_gnt | output | 1 | Coefficient read granted on the memory port |
| coef_zack | output | 1 | Zero coefficient accepted without a read |
| parm_gnt | output | 1 | Parameter read granted on the memory port |
| ram_re | output | 1 | Memory read enable |
| ram_addr | output | ADDR_W | Memory read address |
| ram_rdata | input | DATA_W | Memory read data, RD_LAT cycles after ram_re |
| rsp_coef_valid | output | 1 | Coefficient response valid |
| rsp_coef_data | output | DATA_W | Coefficient response word |
| rsp_parm_valid | output | 1 | Parameter response valid |
| rsp_parm_data | output | DATA_W | Parameter response word |

## Verification
Every cycle, the assertions check the grant decision against the request, zero and buffer-full inputs: exclusivity, coefficient precedence, the stall while full, and the hand-over of the port on a zero coefficient. With a one-cycle read latency they also check that each grant leads to a response on the matching channel, and that a zero is returned for a skipped coefficient. The actual data words, the address sent for each client, the ordering of zeros among real reads, and the quiet outputs around reset can only be shown by the bench. It runs a memory model and a queue-based reference over directed and random request patterns.

// File: rtl/synelem_rd_arb_pkg.sv
package synelem_rd_arb_pkg;

   typedef enum logic {
      OWN_COEF = 1'b0,
      OWN_PARM = 1'b1
   } port_owner_e;

   typedef struct packed {
      logic coef_vld;
      logic coef_zero;
      logic parm_vld;
   } rsp_tag_t;

endpackage

// File: rtl/synelem_rd_prio.sv
module synelem_rd_prio
   import synelem_rd_arb_pkg::*;
(
   input  logic        coef_req,
   input  logic        coef_zero,
   input  logic        parm_req,
   input  logic        xform_full,
   output logic        coef_gnt,
   output logic        coef_zack,
   output logic        parm_gnt,
   output port_owner_e owner
);

   logic coef_live;

   always_comb begin
      coef_live = coef_req && !xform_full;
      coef_gnt  = coef_live && !coef_zero;
      coef_zack = coef_live && coef_zero;
      parm_gnt  = parm_req && !coef_gnt;
      owner     = coef_gnt ? OWN_COEF : OWN_PARM;
   end

endmodule

// File: rtl/synelem_rd_rsp_pipe.sv
module synelem_rd_rsp_pipe
   import synelem_rd_arb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rsp_tag_t          tag_in,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rsp_coef_valid,
   output logic [DATA_W-1:0] rsp_coef_data,
   output logic              rsp_parm_valid,
   output logic [DATA_W-1:0] rsp_parm_data
);

   localparam int LAST = RD_LAT - 1;

   rsp_tag_t stage [RD_LAT];

   generate
      if (RD_LAT < 1) begin : g_bad_lat
         $error("synelem_rd_rsp_pipe: RD_LAT must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("synelem_rd_rsp_pipe: DATA_W must be at least 1");
      end
      for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[0] <= '0;
               else        stage[0] <= tag_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   always_comb begin
      rsp_coef_valid = stage[LAST].coef_vld;
      rsp_coef_data  = stage[LAST].coef_zero ? '0 : ram_rdata;
      rsp_parm_valid = stage[LAST].parm_vld;
      rsp_parm_data  = ram_rdata;
   end

endmodule

// File: rtl/synelem_rd_arb.sv
module synelem_rd_arb
   import synelem_rd_arb_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_req,
   input  logic              coef_zero,
   input  logic [ADDR_W-1:0] coef_addr,
   input  logic              parm_req,
   input  logic [ADDR_W-1:0] parm_addr,
   input  logic              xform_full,
   output logic              coef_gnt,
   output logic              coef_zack,
   output logic              parm_gnt,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rsp_coef_valid,
   output logic [DATA_W-1:0] rsp_coef_data,
   output logic              rsp_parm_valid,
   output logic [DATA_W-1:0] rsp_parm_data
);

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("synelem_rd_arb: ADDR_W must be at least 1");
      end
   endgenerate

   port_owner_e owner;
   rsp_tag_t    tag_now;

   synelem_rd_prio u_prio (
      .coef_req   (coef_req),
      .coef_zero  (coef_zero),
      .parm_req   (parm_req),
      .xform_full (xform_full),
      .coef_gnt   (coef_gnt),
      .coef_zack  (coef_zack),
      .parm_gnt   (parm_gnt),
      .owner      (owner)
   );

   always_comb begin
      ram_re           = coef_gnt || parm_gnt;
      ram_addr         = (owner == OWN_COEF) ? coef_addr : parm_addr;
      tag_now.coef_vld  = coef_gnt || coef_zack;
      tag_now.coef_zero = coef_zack;
      tag_now.parm_vld  = parm_gnt;
   end

   synelem_rd_rsp_pipe #(
      .DATA_W (DATA_W),
      .RD_LAT (RD_LAT)
   ) u_pipe (
      .clk            (clk),
      .rst_n          (rst_n),
      .tag_in         (tag_now),
      .ram_rdata      (ram_rdata),
      .rsp_coef_valid (rsp_coef_valid),
      .rsp_coef_data  (rsp_coef_data),
      .rsp_parm_valid (rsp_parm_valid),
      .rsp_parm_data  (rsp_parm_data)
   );

endmodule

// File: rtl/synelem_rd_arb_chk.sv
module synelem_rd_arb_chk #(
   parameter int DATA_W = 16,
   parameter int RD_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coef_req,
   input logic              coef_zero,
   input logic              parm_req,
   input logic              xform_full,
   input logic              coef_gnt,
   input logic              coef_zack,
   input logic              parm_gnt,
   input logic              rsp_coef_valid,
   input logic [DATA_W-1:0] rsp_coef_data,
   input logic              rsp_parm_valid
);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(coef_gnt && parm_gnt));

   p_coef_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_gnt || coef_zack) |-> coef_req);

   p_parm_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      parm_gnt |-> parm_req);

   p_coef_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_req && !coef_zero && !xform_full) |-> (coef_gnt && !parm_gnt));

   p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_req && coef_zero && !xform_full) |->
         (coef_zack && !coef_gnt && (parm_gnt == parm_req)));

   p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xform_full |-> (!coef_gnt && !coef_zack && (parm_gnt == parm_req)));

   generate
      if (RD_LAT == 1) begin : g_lat1
         p_coef_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_gnt || coef_zack) |=> rsp_coef_valid);

         p_parm_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
            parm_gnt |=> rsp_parm_valid);

         p_zero_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
            coef_zack |=> (rsp_coef_data == '0));
      end
   endgenerate

endmodule

bind synelem_rd_arb synelem_rd_arb_chk #(
   .DATA_W (DATA_W),
   .RD_LAT (RD_LAT)
) u_chk (.*);

// File: tb/sim_synelem_rd_arb.sv
module sim_synelem_rd_arb;

   localparam int AW  = 9;
   localparam int DW  = 16;
   localparam int LAT = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          coef_req = 1'b0, coef_zero = 1'b0, parm_req = 1'b0, xform_full = 1'b0;
   logic [AW-1:0] coef_addr = '0, parm_addr = '0;
   logic          coef_gnt, coef_zack, parm_gnt, ram_re;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_rdata = '0;
   logic          rsp_coef_valid, rsp_parm_valid;
   logic [DW-1:0] rsp_coef_data, rsp_parm_data;

   int n_checks = 0;
   int n_errors = 0;
   int q_coef[$];
   int q_parm[$];

   always #4 clk = ~clk;

   synelem_rd_arb #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .coef_req(coef_req), .coef_zero(coef_zero), .coef_addr(coef_addr),
      .parm_req(parm_req), .parm_addr(parm_addr), .xform_full(xform_full),
      .coef_gnt(coef_gnt), .coef_zack(coef_zack), .parm_gnt(parm_gnt),
      .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
      .rsp_coef_valid(rsp_coef_valid), .rsp_coef_data(rsp_coef_data),
      .rsp_parm_valid(rsp_parm_valid), .rsp_parm_data(rsp_parm_data)
   );

   function automatic int mem_word(input int a);
      return ((a * 37) + 11) & ((1 << DW) - 1);
   endfunction

   // memory model: one-cycle synchronous read
   always @(posedge clk) if (ram_re) ram_rdata <= DW'(mem_word(int'(ram_addr)));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // responses due this cycle, then grants from current inputs
   task automatic compare_cycle(input string tag);
      int  e_cg, e_zk, e_pg, e_addr;
      bit  coef_seen = 0;
      check("R7/R8 coef valid", int'(rsp_coef_valid), int'(q_coef.size() > 0));
      if (q_coef.size() > 0) begin
         coef_seen = 1;
         check("R8 coef data order", int'(rsp_coef_data), q_coef.pop_front());
      end
      check("R7 parm valid", int'(rsp_parm_valid), int'(q_parm.size() > 0));
      if (q_parm.size() > 0) check("R7 parm data", int'(rsp_parm_data), q_parm.pop_front());
      e_cg = 0; e_zk = 0; e_pg = 0; e_addr = -1;
      if (coef_req && !xform_full) begin
         if (coef_zero) e_zk = 1;
         else begin e_cg = 1; e_addr = int'(coef_addr); end
      end
      if (parm_req && e_cg == 0) begin e_pg = 1; e_addr = int'(parm_addr); end
      check({tag, " coef_gnt"}, int'(coef_gnt), e_cg);
      check({tag, " coef_zack"}, int'(coef_zack), e_zk);
      check({tag, " parm_gnt"}, int'(parm_gnt), e_pg);
      check({tag, " R6 ram_re"}, int'(ram_re), int'(e_cg | e_pg));
      if (e_addr >= 0) check({tag, " ram_addr"}, int'(ram_addr), e_addr);
      if (e_cg == 1) q_coef.push_back(mem_word(int'(coef_addr)));
      if (e_zk == 1) q_coef.push_back(0);
      if (e_pg == 1) q_parm.push_back(mem_word(int'(parm_addr)));
      if (coef_seen) begin end
   endtask

   task automatic step(input bit cr, input bit cz, input int ca,
                       input bit pr, input int pa, input bit fl, input string tag);
      @(posedge clk); #1;
      coef_req = cr; coef_zero = cz; coef_addr = AW'(ca);
      parm_req = pr; parm_addr = AW'(pa); xform_full = fl;
      @(negedge clk);
      compare_cycle(tag);
   endtask

   initial begin
      #(8 * 200000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      // R1: quiet during reset
      coef_req = 1'b1; parm_req = 1'b1; coef_addr = 9'd5; parm_addr = 9'd6;
      repeat (3) begin
         @(negedge clk);
         check("R1 coef valid in reset", int'(rsp_coef_valid), 0);
         check("R1 parm valid in reset", int'(rsp_parm_valid), 0);
      end
      coef_req = 1'b0; parm_req = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 coef valid after reset", int'(rsp_coef_valid), 0);
      check("R1 parm valid after reset", int'(rsp_parm_valid), 0);
      compare_cycle("R9 idle");

      // R2 / R3: coefficient read beats parameter read
      step(1, 0, 17, 0, 0, 0, "R2");
      step(1, 0, 18, 1, 200, 0, "R3");
      step(1, 0, 19, 1, 200, 0, "R3");
      // R4: zero coefficients hand the port over
      step(1, 1, 20, 1, 201, 0, "R4");
      step(1, 1, 21, 0, 0, 0, "R4 no read R9");
      step(1, 0, 22, 1, 202, 0, "R8 order");
      step(1, 1, 23, 1, 203, 0, "R8 order");
      // R5: buffer full stalls coefficient path, held request
      step(1, 0, 24, 1, 204, 1, "R5");
      step(1, 0, 24, 1, 205, 1, "R5");
      step(1, 1, 24, 0, 0, 1, "R5 R9 stalled");
      step(1, 0, 24, 0, 0, 1, "R5 R9 stalled");
      step(1, 0, 24, 1, 206, 0, "R2 resume");
      step(0, 0, 0, 1, 511, 0, "R7 parm alone");
      step(0, 0, 0, 0, 0, 0, "R9 idle");
      step(0, 0, 0, 0, 0, 0, "R9 idle");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % 512),
              ($urandom % 2) == 1, int'($urandom % 512), ($urandom % 5) == 0, "R6 mix");
      end
      step(0, 0, 0, 0, 0, 0, "R9 drain");
      check("R7 queues drained", q_coef.size() + q_parm.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule